// File: doc/BRIEF.md
# Reference Divider Chain with Band-Selected Comparison Reference

This block takes a 4 MHz reference clock and divides it down through four cascaded stages. The output is a set of slower timing signals for a radio frequency synthesizer. The first stage divides by 8 and gives a 500 kHz square wave that clocks an external controller. The second stage divides by 40 and gives a 12.5 kHz square wave, which is the comparison reference for the FM band. The third stage divides by 25 and gives a 500 Hz single-cycle pulse, which is the comparison reference for the AM band. The last stage divides by 10 and gives a 50 Hz square wave that a controller can count for time of day.

Each stage moves forward only in the cycle in which the stage before it reaches terminal count. All taps therefore stay phase-locked to one another. A band-select input picks which comparison reference is sent to the phase comparator as a one-cycle pulse. A change of band takes effect only at a pulse of the reference currently in use, so the phase comparator never sees a shortened interval.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage counter is cleared to zero. After that edge, `ctl_clk_o`, `fm_ref_o`, `am_ref_o`, `tod_o` and `ref_o` are all 0.
- R2: Count the rising edges since reset was released as t, where the first edge that samples `rst` low is t = 1. After edge t, `ctl_clk_o` is 1 exactly when (t mod 8) >= 4.
- R3: After edge t, `fm_ref_o` is 1 exactly when (floor(t/8) mod 40) >= 20. It changes only in a cycle in which `ctl_clk_o` has just fallen.
- R4: `am_ref_o` is 1 for exactly one cycle after each edge t that is a nonzero multiple of 8000, and 0 at every other time.
- R5: After edge t, `tod_o` is 1 exactly when (floor(t/8000) mod 10) >= 5. It changes only in a cycle in which `am_ref_o` is 1.
- R6: With FM selected (`band_fm_i` = 1), `ref_o` is a one-cycle pulse after each edge t that is a nonzero multiple of 320. Each such pulse coincides with a falling edge of `fm_ref_o`.
- R7: With AM selected (`band_fm_i` = 0), `ref_o` is a one-cycle pulse after each edge t that is a nonzero multiple of 8000.
- R8: At any edge that produces a pulse on `ref_o`, the value of `band_fm_i` is sampled and becomes the selection for all later pulses. At any other edge the selection holds. The pulse produced at the switching edge still belongs to the old band. A change that is reverted before the next pulse has no effect.
- R9: The selection in force when reset is released is the value of `band_fm_i` sampled during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| band_fm_i | input | 1 | Band select: 1 = FM (12.5 kHz reference), 0 = AM (500 Hz reference) |
| ctl_clk_o | output | 1 | 500 kHz square wave for the controller |
| fm_ref_o | output | 1 | 12.5 kHz square wave |
| am_ref_o | output | 1 | 500 Hz one-cycle pulse |
| tod_o | output | 1 | 50 Hz time-of-day square wave |
| ref_o | output | 1 | Selected comparison reference, one-cycle pulse |

## Verification
The hardest case is an edge where an FM reference pulse and an AM reference pulse fall in the same cycle. This happens every 8000 cycles, and at that edge a pending band change is committed while the old band's pulse is still being emitted. The bench provokes this by changing the band between pulses in both directions, and by changing it and reverting it before the next pulse arrives. Each cycle it compares `ref_o` against a model of the effective band that is updated only at pulse edges. The run also covers a time-of-day edge, which coincides with both reference pulses and with a controller clock fall.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned DEF_DIV_CTL = 8;
  localparam int unsigned DEF_DIV_FM  = 40;
  localparam int unsigned DEF_DIV_AM  = 25;
  localparam int unsigned DEF_DIV_TOD = 10;

  typedef enum logic {BAND_AM = 1'b0, BAND_FM = 1'b1} band_e;
endpackage

// File: rtl/refdiv_stage.sv
module refdiv_stage #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tc_o,
  output logic tap_o
);
  localparam int unsigned CW   = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int unsigned HALF = RATIO / 2;
  localparam bit          SQ   = (RATIO % 2) == 0;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          tap_q;

  always_comb begin
    tc_o    = en_i && (cnt_q == LAST);
    cnt_nxt = cnt_q;
    if (en_i) cnt_nxt = tc_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  generate
    if (SQ) begin : g_square
      always_ff @(posedge clk) begin
        if (rst) tap_q <= 1'b0;
        else     tap_q <= (cnt_nxt >= CW'(HALF));
      end
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) tap_q <= 1'b0;
        else     tap_q <= tc_o;
      end
      // R4
      pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        tap_q |=> !tap_q);
    end
  endgenerate

  assign tap_o = tap_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> (cnt_q == '0));
endmodule

// File: rtl/refdiv_bandsel.sv
module refdiv_bandsel (
  input  logic clk,
  input  logic rst,
  input  logic band_fm_i,
  input  logic tc_fm_i,
  input  logic tc_am_i,
  output logic ref_o
);
  import refdiv_pkg::*;

  band_e band_q;
  logic  ref_q;
  logic  sel_tc;

  assign sel_tc = (band_q == BAND_FM) ? tc_fm_i : tc_am_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      band_q <= band_e'(band_fm_i);
      ref_q  <= 1'b0;
    end else begin
      ref_q <= sel_tc;
      if (sel_tc) band_q <= band_e'(band_fm_i);
    end
  end

  assign ref_o = ref_q;

  // R8
  ref_single_chk: assert property (@(posedge clk) disable iff (rst)
    ref_q |=> !ref_q);
  // R8
  band_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_q && !$past(rst) |-> (band_q == $past(band_q)));
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int unsigned DIV_CTL = refdiv_pkg::DEF_DIV_CTL,
  parameter int unsigned DIV_FM  = refdiv_pkg::DEF_DIV_FM,
  parameter int unsigned DIV_AM  = refdiv_pkg::DEF_DIV_AM,
  parameter int unsigned DIV_TOD = refdiv_pkg::DEF_DIV_TOD
) (
  input  logic clk,
  input  logic rst,
  input  logic band_fm_i,
  output logic ctl_clk_o,
  output logic fm_ref_o,
  output logic am_ref_o,
  output logic tod_o,
  output logic ref_o
);
  localparam int unsigned NSTG = 4;
  localparam int unsigned RATIOS [NSTG] = '{DIV_CTL, DIV_FM, DIV_AM, DIV_TOD};

  logic [NSTG:0]   en;
  logic [NSTG-1:0] tap;

  assign en[0] = 1'b1;

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
      refdiv_stage #(.RATIO(RATIOS[s])) u_stage (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en[s]),
        .tc_o  (en[s+1]),
        .tap_o (tap[s])
      );
    end
  endgenerate

  assign ctl_clk_o = tap[0];
  assign fm_ref_o  = tap[1];
  assign am_ref_o  = tap[2];
  assign tod_o     = tap[3];

  refdiv_bandsel u_sel (
    .clk       (clk),
    .rst       (rst),
    .band_fm_i (band_fm_i),
    .tc_fm_i   (en[2]),
    .tc_am_i   (en[3]),
    .ref_o     (ref_o)
  );

  // R3
  fm_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (fm_ref_o != $past(fm_ref_o)) |-> (!ctl_clk_o && $past(ctl_clk_o)));
  // R5
  tod_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (tod_o != $past(tod_o)) |-> am_ref_o);
  // R6
  fm_ref_align_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_o && !am_ref_o) |-> (!fm_ref_o && $past(fm_ref_o)));
endmodule

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic band_fm = 1'b1;
  logic ctl_clk, fm_ref, am_ref, tod, ref_p;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit eff = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refdiv_top u0 (
    .clk       (clk),
    .rst       (rst),
    .band_fm_i (band_fm),
    .ctl_clk_o (ctl_clk),
    .fm_ref_o  (fm_ref),
    .am_ref_o  (am_ref),
    .tod_o     (tod),
    .ref_o     (ref_p)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s t=%0d actual=%0b expected=%0b", req, t, act, exp);
    end
  endtask

  // R1 / R9
  task automatic do_reset(input logic band);
    rst = 1'b1;
    band_fm = band;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ctl", ctl_clk, 1'b0);
    chk("R1 fm", fm_ref, 1'b0);
    chk("R1 am", am_ref, 1'b0);
    chk("R1 tod", tod, 1'b0);
    chk("R1 ref", ref_p, 1'b0);
    rst = 1'b0;
    t = 0;
    eff = band;
  endtask

  // one cycle against the model; checks R2..R8
  task automatic step();
    logic e_ref;
    @(posedge clk);
    t++;
    @(negedge clk);
    chk("R2", ctl_clk, logic'((t % 8) >= 4));
    chk("R3", fm_ref, logic'(((t / 8) % 40) >= 20));
    chk("R4", am_ref, logic'((t % 8000) == 0));
    chk("R5", tod, logic'(((t / 8000) % 10) >= 5));
    e_ref = eff ? logic'((t % 320) == 0) : logic'((t % 8000) == 0);
    chk(eff ? "R6/R8" : "R7/R8", ref_p, e_ref);
    if (e_ref) eff = band_fm;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic test_fm_am_switch();
    do_reset(1'b1);
    run(700);
    band_fm = 1'b0;
    run(7400);
    band_fm = 1'b1;
    run(8300);
    band_fm = 1'b0;
    run(100);
    band_fm = 1'b1;
    run(400);
  endtask

  task automatic test_am_start();
    do_reset(1'b0);
    run(8100);
    band_fm = 1'b1;
    run(800);
  endtask

  task automatic test_tod();
    do_reset(1'b1);
    run(80010);
  endtask

  initial begin
    test_am_start();
    test_fm_am_switch();
    test_tod();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog t=%0d actual=hung expected=finished", t);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule